// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This block forms the memory address for one load or store per clock in a pipelined processor with sixteen general registers: eight data registers (numbers 0 to 7) and eight address registers (numbers 8 to 15). It is given the current register file contents, an addressing-mode code, a base register number and the decoded extension fields. The extension fields are an index register number, an index width flag, a scale code and a signed 8-bit displacement.

Four modes are handled. Plain indirect uses any register as the pointer. Post-increment on an address register also returns the stepped pointer for write-back. Based indexed adds base, displacement and scaled index. The base-suppressed indexed mode adds only displacement and scaled index. Every mode takes the same single clock. The result is registered, and a new request can be accepted on every cycle.

Top module: `ea_gen_top`

## Requirements
- R1: While `rst` is high at a clock edge, `ea_valid_o` and `wb_en_o` are 0 after that edge.
- R2: Mode 0 (indirect) gives `ea_o` equal to the register named by `base_num_i`. Any of the 16 registers may be the pointer, data registers included. `wb_en_o` stays 0.
- R3: Mode 1 (post-increment) with an address-register base (`base_num_i[3]`=1) gives `ea_o` equal to the old base value. It sets `wb_en_o`=1, sets `wb_num_o` to `base_num_i`, and sets `wb_val_o` to base+1, +2 or +4 for `opsize_i` 0 (byte), 1 (word) or 2/3 (long).
- R4: Mode 1 with a data-register base (`base_num_i[3]`=0) acts as plain indirect, and `wb_en_o` stays 0.
- R5: Mode 2 (indexed) gives base + sign-extended `disp_i` + scaled index.
- R6: With `idx_long_i`=0 the index is the low 16 bits of the register, sign-extended. With `idx_long_i`=1 it is all 32 bits.
- R7: `scale_i` codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R8: Mode 3 (base suppressed) gives sign-extended `disp_i` + scaled index, with the base taken as zero.
- R9: All sums wrap modulo 2^32.
- R10: A request with `valid_i`=1 produces its result and `ea_valid_o`=1 after exactly one clock edge. If `valid_i`=0 at an edge, `ea_valid_o` and `wb_en_o` are 0 after it.
- R11: `idx_num_i` may select any of the 16 registers, address registers included, as the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Request present this cycle |
| mode_i | input | 2 | 0 indirect, 1 post-increment, 2 indexed, 3 indexed without base |
| base_num_i | input | 4 | Base register number (bit 3 set = address register) |
| idx_num_i | input | 4 | Index register number |
| idx_long_i | input | 1 | 1 = 32-bit index, 0 = sign-extended 16-bit index |
| scale_i | input | 2 | Index scale code (factor 1, 2, 4, 8) |
| disp_i | input | 8 | Signed displacement |
| opsize_i | input | 2 | Operand size for post-increment step |
| reg_file_i | input | 512 | All 16 registers, register k at bits 32k+31:32k |
| ea_valid_o | output | 1 | Result valid |
| ea_o | output | 32 | Effective address |
| wb_en_o | output | 1 | Base write-back enable |
| wb_num_o | output | 4 | Register to write back |
| wb_val_o | output | 32 | Stepped base value |

## Verification
The bench builds the block with its default parameters: 32-bit registers, a file of sixteen registers and an 8-bit displacement. These values give the full split between data and address registers. The register file is loaded with values whose low half has bit 15 set, so the two index widths give different sums. Base values sit near the top of the address space, so wrap-around of the adder is reached. Every scale code and every operand step size is exercised.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {
    AM_IND     = 2'd0,
    AM_POSTINC = 2'd1,
    AM_INDEX   = 2'd2,
    AM_NOBASE  = 2'd3
  } am_mode_e;

  typedef enum logic [1:0] {
    OS_BYTE = 2'd0,
    OS_WORD = 2'd1,
    OS_LONG = 2'd2,
    OS_ALT  = 2'd3
  } op_size_e;
endpackage

// File: rtl/ea_reg_mux.sv
module ea_reg_mux #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int SW  = $clog2(NREG)
) (
  input  logic [NREG*DW-1:0] regs_i,
  input  logic [SW-1:0]      sel_i,
  output logic [DW-1:0]      val_o
);
  logic [DW-1:0] slots [NREG];

  for (genvar k = 0; k < NREG; k++) begin : g_slot
    assign slots[k] = regs_i[k*DW +: DW];
  end

  assign val_o = slots[sel_i];
endmodule

// File: rtl/ea_index_scale.sv
module ea_index_scale #(
  parameter int DW = 32,
  parameter int HW = 16
) (
  input  logic [DW-1:0] raw_i,
  input  logic          long_i,
  input  logic [1:0]    scale_i,
  output logic [DW-1:0] scaled_o
);
  logic [DW-1:0] ext_idx;

  always_comb begin
    if (long_i) ext_idx = raw_i;
    else        ext_idx = {{(DW-HW){raw_i[HW-1]}}, raw_i[HW-1:0]};
    scaled_o = ext_idx << scale_i;
  end
endmodule

// File: rtl/ea_step_gen.sv
module ea_step_gen #(
  parameter int DW = 32
) (
  input  ea_pkg::op_size_e osz_i,
  output logic [DW-1:0]    step_o
);
  always_comb begin
    case (osz_i)
      ea_pkg::OS_BYTE: step_o = DW'(1);
      ea_pkg::OS_WORD: step_o = DW'(2);
      default:         step_o = DW'(4);
    endcase
  end
endmodule

// File: rtl/ea_gen_top.sv
module ea_gen_top #(
  parameter int DW     = 32,
  parameter int NREG   = 16,
  parameter int DISP_W = 8,
  parameter int HW     = 16,
  localparam int SW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [1:0]        mode_i,
  input  logic [SW-1:0]     base_num_i,
  input  logic [SW-1:0]     idx_num_i,
  input  logic              idx_long_i,
  input  logic [1:0]        scale_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [1:0]        opsize_i,
  input  logic [NREG*DW-1:0] reg_file_i,
  output logic              ea_valid_o,
  output logic [DW-1:0]     ea_o,
  output logic              wb_en_o,
  output logic [SW-1:0]     wb_num_o,
  output logic [DW-1:0]     wb_val_o
);
  import ea_pkg::*;

  am_mode_e      mode;
  logic [DW-1:0] base_val, idx_raw, idx_scaled, step, disp_ext;
  logic [DW-1:0] base_term, idx_term, ea_next, wb_next;
  logic          is_addr_base, do_wb;

  assign mode = am_mode_e'(mode_i);

  ea_reg_mux #(.DW(DW), .NREG(NREG)) base_mux_i (
    .regs_i(reg_file_i), .sel_i(base_num_i), .val_o(base_val));

  ea_reg_mux #(.DW(DW), .NREG(NREG)) idx_mux_i (
    .regs_i(reg_file_i), .sel_i(idx_num_i), .val_o(idx_raw));

  ea_index_scale #(.DW(DW), .HW(HW)) scale_i_u (
    .raw_i(idx_raw), .long_i(idx_long_i), .scale_i(scale_i),
    .scaled_o(idx_scaled));

  ea_step_gen #(.DW(DW)) step_i_u (
    .osz_i(op_size_e'(opsize_i)), .step_o(step));

  assign disp_ext     = {{(DW-DISP_W){disp_i[DISP_W-1]}}, disp_i};
  assign is_addr_base = base_num_i[SW-1];

  always_comb begin
    base_term = base_val;
    idx_term  = '0;
    do_wb     = 1'b0;
    case (mode)
      AM_IND:     ;
      AM_POSTINC: do_wb = is_addr_base;
      AM_INDEX:   idx_term = idx_scaled + disp_ext;
      AM_NOBASE: begin
        base_term = '0;
        idx_term  = idx_scaled + disp_ext;
      end
      default:    ;
    endcase
    ea_next = base_term + idx_term;
    wb_next = base_val + step;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ea_valid_o <= 1'b0;
      wb_en_o    <= 1'b0;
      ea_o       <= '0;
      wb_num_o   <= '0;
      wb_val_o   <= '0;
    end else begin
      ea_valid_o <= valid_i;
      wb_en_o    <= valid_i & do_wb;
      if (valid_i) begin
        ea_o     <= ea_next;
        wb_num_o <= base_num_i;
        wb_val_o <= wb_next;
      end
    end
  end
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk #(
  parameter int DW = 32,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          valid_i,
  input logic [1:0]    mode_i,
  input logic [SW-1:0] base_num_i,
  input logic          ea_valid_o,
  input logic [DW-1:0] ea_o,
  input logic          wb_en_o,
  input logic [SW-1:0] wb_num_o,
  input logic [DW-1:0] wb_val_o
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!ea_valid_o && !wb_en_o));

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> ea_valid_o);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!ea_valid_o && !wb_en_o));

  p_wb_addr_only_r4: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> (ea_valid_o && wb_num_o[SW-1]));

  p_wb_target_r3: assert property (@(posedge clk) disable iff (rst)
    (valid_i && mode_i == 2'd1 && base_num_i[SW-1]) |=>
      (wb_en_o && wb_num_o == $past(base_num_i)));

  p_step_size_r3: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> ((wb_val_o - ea_o) == DW'(1) || (wb_val_o - ea_o) == DW'(2)
                 || (wb_val_o - ea_o) == DW'(4)));
endmodule

bind ea_gen_top ea_gen_chk #(.DW(DW), .SW(SW)) chk_i (
  .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i),
  .base_num_i(base_num_i), .ea_valid_o(ea_valid_o), .ea_o(ea_o),
  .wb_en_o(wb_en_o), .wb_num_o(wb_num_o), .wb_val_o(wb_val_o));

// File: tb/ea_gen_top_tb_top.sv
module ea_gen_top_tb_top;
  localparam int DW = 32;
  localparam int NREG = 16;

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  base;
    logic [3:0]  idx;
    logic        lng;
    logic [1:0]  scl;
    logic [7:0]  disp;
    logic [1:0]  osz;
    logic [31:0] ea;
    logic        we;
    logic [31:0] wv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 17;
  // Register file: D0=1000 D1=0001FFFE D2=10 D3=FFFFFFF0 A0=20000000
  // A1=00008000 A2=FFFFFFF0 A3=100 A7=400000F0
  localparam vec_t VT [NV] = '{
    '{2'd0, 4'd0,  4'd0, 1'b0, 2'd0, 8'h00, 2'd2, 32'h0000_1000, 1'b0, 32'h0, 8'd2},  // R2 data ptr
    '{2'd0, 4'd8,  4'd0, 1'b0, 2'd0, 8'h00, 2'd2, 32'h2000_0000, 1'b0, 32'h0, 8'd2},  // R2 addr ptr
    '{2'd1, 4'd11, 4'd0, 1'b0, 2'd0, 8'h00, 2'd0, 32'h0000_0100, 1'b1, 32'h0000_0101, 8'd3}, // R3 byte
    '{2'd1, 4'd11, 4'd0, 1'b0, 2'd0, 8'h00, 2'd1, 32'h0000_0100, 1'b1, 32'h0000_0102, 8'd3}, // R3 word
    '{2'd1, 4'd8,  4'd0, 1'b0, 2'd0, 8'h00, 2'd2, 32'h2000_0000, 1'b1, 32'h2000_0004, 8'd3}, // R3 long
    '{2'd1, 4'd15, 4'd0, 1'b0, 2'd0, 8'h00, 2'd3, 32'h4000_00F0, 1'b1, 32'h4000_00F4, 8'd3}, // R3 code 3
    '{2'd1, 4'd0,  4'd0, 1'b0, 2'd0, 8'h00, 2'd2, 32'h0000_1000, 1'b0, 32'h0, 8'd4},  // R4
    '{2'd2, 4'd8,  4'd1, 1'b0, 2'd0, 8'h10, 2'd2, 32'h2000_000E, 1'b0, 32'h0, 8'd6},  // R5 R6 word
    '{2'd2, 4'd8,  4'd1, 1'b1, 2'd0, 8'h10, 2'd2, 32'h2002_000E, 1'b0, 32'h0, 8'd6},  // R6 long
    '{2'd2, 4'd8,  4'd2, 1'b1, 2'd3, 8'hFC, 2'd2, 32'h2000_007C, 1'b0, 32'h0, 8'd7},  // R7 x8
    '{2'd2, 4'd11, 4'd2, 1'b1, 2'd1, 8'h00, 2'd2, 32'h0000_0120, 1'b0, 32'h0, 8'd7},  // R7 x2
    '{2'd2, 4'd11, 4'd2, 1'b1, 2'd2, 8'h00, 2'd2, 32'h0000_0140, 1'b0, 32'h0, 8'd7},  // R7 x4
    '{2'd2, 4'd8,  4'd9, 1'b0, 2'd0, 8'h00, 2'd2, 32'h1FFF_8000, 1'b0, 32'h0, 8'd11}, // R11
    '{2'd3, 4'd8,  4'd2, 1'b1, 2'd2, 8'h08, 2'd2, 32'h0000_0048, 1'b0, 32'h0, 8'd8},  // R8
    '{2'd3, 4'd8,  4'd10,1'b1, 2'd0, 8'h80, 2'd2, 32'hFFFF_FF70, 1'b0, 32'h0, 8'd8},  // R8
    '{2'd2, 4'd10, 4'd2, 1'b1, 2'd0, 8'h20, 2'd2, 32'h0000_0020, 1'b0, 32'h0, 8'd9},  // R9
    '{2'd2, 4'd3,  4'd11,1'b1, 2'd0, 8'h00, 2'd2, 32'h0000_00F0, 1'b0, 32'h0, 8'd9}   // R9
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid_i = 1'b0;
  logic [1:0] mode_i = '0;
  logic [3:0] base_num_i = '0, idx_num_i = '0;
  logic idx_long_i = 1'b0;
  logic [1:0] scale_i = '0, opsize_i = '0;
  logic [7:0] disp_i = '0;
  logic [NREG*DW-1:0] reg_file_i;
  logic ea_valid_o, wb_en_o;
  logic [31:0] ea_o, wb_val_o;
  logic [3:0] wb_num_o;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  ea_gen_top dut_i (
    .clk(clk), .rst(rst), .valid_i(valid_i), .mode_i(mode_i),
    .base_num_i(base_num_i), .idx_num_i(idx_num_i), .idx_long_i(idx_long_i),
    .scale_i(scale_i), .disp_i(disp_i), .opsize_i(opsize_i),
    .reg_file_i(reg_file_i), .ea_valid_o(ea_valid_o), .ea_o(ea_o),
    .wb_en_o(wb_en_o), .wb_num_o(wb_num_o), .wb_val_o(wb_val_o));

  function automatic logic [31:0] regval(int k);
    case (k)
      0: return 32'h0000_1000;
      1: return 32'h0001_FFFE;
      2: return 32'h0000_0010;
      3: return 32'hFFFF_FFF0;
      8: return 32'h2000_0000;
      9: return 32'h0000_8000;
      10: return 32'hFFFF_FFF0;
      11: return 32'h0000_0100;
      default: return (k < 8) ? 32'(k * 256) : 32'h4000_0000 + 32'(k * 16);
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(vec_t v);
    mode_i = v.mode; base_num_i = v.base; idx_num_i = v.idx;
    idx_long_i = v.lng; scale_i = v.scl; disp_i = v.disp; opsize_i = v.osz;
  endtask

  initial begin
    #20000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NREG; k++) reg_file_i[k*DW +: DW] = regval(k);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", 32'(ea_valid_o), 32'd0);
    chk("R1 wb_en", 32'(wb_en_o), 32'd0);
    rst = 1'b0;
    // Table walk, one request per cycle (R10 back-to-back)
    valid_i = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VT[i]);
      @(negedge clk);
      chk($sformatf("R%0d ea v%0d", VT[i].req, i), ea_o, VT[i].ea);
      chk($sformatf("R10 valid v%0d", i), 32'(ea_valid_o), 32'd1);
      chk($sformatf("R%0d wb_en v%0d", VT[i].req, i), 32'(wb_en_o), 32'(VT[i].we));
      if (VT[i].we) begin
        chk($sformatf("R3 wb_val v%0d", i), wb_val_o, VT[i].wv);
        chk($sformatf("R3 wb_num v%0d", i), 32'(wb_num_o), 32'(VT[i].base));
      end
    end
    // R10 idle: post-increment request without valid leaves outputs quiet
    drive(VT[4]);
    valid_i = 1'b0;
    @(negedge clk);
    chk("R10 idle valid", 32'(ea_valid_o), 32'd0);
    chk("R10 idle wb_en", 32'(wb_en_o), 32'd0);
    // R1 reset mid-run with a valid post-increment request
    valid_i = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid valid", 32'(ea_valid_o), 32'd0);
    chk("R1 mid wb_en", 32'(wb_en_o), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 after reset ea", ea_o, 32'h2000_0000);
    chk("R3 after reset wb", wb_val_o, 32'h2000_0004);
    valid_i = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule